// File: doc/BRIEF.md
# Four-Channel PCM Highway Slot Interface

This block joins four voice channels to one serial PCM highway that runs on a single bit clock. In the transmit direction each channel has its own frame sync. When a channel's sync arrives, the block takes that channel's 8-bit parallel sample and shifts it onto one shared output line, most significant bit first. The line is driven only during a channel's slot; at all other times the enable is low and the external pad driver leaves the line floating. In the receive direction each channel also has its own sync. The block samples the shared input line during that channel's slot and shows the assembled byte on a per-channel parallel output, together with a valid strobe one cycle wide.

Two sync styles are supported, chosen by one static mode input. In short-frame mode a sync one clock wide marks the bit period just before the first data bit. In long-frame mode the first data bit falls in the period in which the sync rises, and the sync stays high across the burst. The mode is examined only when a slot starts, so a slot that is already running keeps the style it began with.

Top module: `pcm_slot_if`

## Requirements
- R1: While reset is high and in the first cycle after it, `rx_valid` is all zero and every `rx_word` lane reads 0; `tx_drive` is low until a transmit sync arrives.
- R2: Short-frame transmit (`long_frame`=0): a channel whose `tx_fsync` bit is high in bit period N drives `tx_bit` in periods N+1 to N+8, sending bits 7 down to 0 of its `tx_word` lane. `tx_drive` is high for exactly those eight periods.
- R3: Long-frame transmit (`long_frame`=1): a channel whose `tx_fsync` bit rises in period N drives bits 7 down to 0 in periods N to N+7, and `tx_drive` is high for exactly those periods.
- R4: When `tx_drive` is low, `tx_bit` is 0.
- R5: The transmitted byte is the value of the channel's `tx_word` lane in the sync period. A change to that lane after the slot has started does not alter the burst.
- R6: Short-frame receive: with `rx_fsync` bit c high in period N, `rx_bit` is sampled on the falling clock edges of periods N+1 to N+8, first bit into bit 7. `rx_valid[c]` is high for the single period N+9, and `rx_word` lane c then holds the byte.
- R7: Long-frame receive: with `rx_fsync` bit c rising in period N, bits are sampled in periods N to N+7, and `rx_valid[c]` pulses in period N+8.
- R8: An `rx_word` lane changes only in the cycle in which its `rx_valid` bit is high. Lanes of channels that had no receive slot keep their value.
- R9: When transmit slots of two or more channels overlap, `tx_bit` carries the lowest-numbered active channel and `tx_overlap` is high in each overlapping period. Every channel keeps its own slot timing.
- R10: A change of `long_frame` during a running slot does not change that slot's timing; the new mode applies from the next sync.
- R11: A further sync pulse on a channel whose slot is still running is ignored and does not extend or restart the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock; transmit changes on the rising edge, receive samples on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| long_frame | input | 1 | Sync style: 1 long-frame, 0 short-frame |
| tx_fsync | input | 4 | Per-channel transmit frame sync, bit c for channel c |
| tx_word | input | 32 | Transmit samples, lane c in bits [8c+7:8c] |
| tx_bit | output | 1 | Serial transmit data for the shared highway |
| tx_drive | output | 1 | High while `tx_bit` must be driven onto the highway |
| tx_overlap | output | 1 | High while transmit slots of more than one channel overlap |
| rx_fsync | input | 4 | Per-channel receive frame sync, bit c for channel c |
| rx_bit | input | 1 | Serial receive data from the shared highway |
| rx_word | output | 32 | Received samples, lane c in bits [8c+7:8c] |
| rx_valid | output | 4 | One-cycle strobe per channel when its byte is complete |

## Verification
A wrong slot counter in a transmit lane shows up within one frame: `tx_drive` is high for seven or nine periods, or the bit sequence is shifted by one position, and the first mismatch appears in the period after the sync. A wrong receive counter shows as a valid strobe one period early or late, or as a byte rotated by one bit. Errors in the sync-style decision show as a one-period shift of the whole burst. Errors in priority show in the first overlapping period as the wrong channel's bit or a missing `tx_overlap`. The bench sweeps both styles over every channel with several data patterns and compares each period against arithmetic expectations.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

    typedef enum logic {
        SYNC_SHORT = 1'b0,
        SYNC_LONG  = 1'b1
    } sync_mode_e;

    function automatic sync_mode_e mode_of(input logic long_sel);
        return long_sel ? SYNC_LONG : SYNC_SHORT;
    endfunction

    // Slot start decision shared by both directions.
    // Long style starts on a rising sync, short style on any sync seen while idle.
    function automatic logic slot_start(input sync_mode_e m, input logic fs_now,
                                        input logic fs_prev, input logic idle);
        if (m == SYNC_LONG)
            return fs_now & ~fs_prev & idle;
        else
            return fs_now & idle;
    endfunction

endpackage

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_slot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         long_frame,
    input  logic         fs,
    input  logic [W-1:0] word,
    output logic         active,
    output logic         bit_o
);
    localparam int CW = $clog2(W + 1);

    logic          fs_q;
    logic [W-1:0]  sh;
    logic [CW-1:0] rem;
    sync_mode_e    m;
    logic          idle;
    logic          start;
    logic          first;

    assign m     = mode_of(long_frame);
    assign idle  = (rem == '0);
    assign start = slot_start(m, fs, fs_q, idle);
    // Long style: the first bit goes out in the period the sync rises (R3)
    assign first = (m == SYNC_LONG) & fs & ~fs_q & idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= 1'b0;
            sh   <= '0;
            rem  <= '0;
        end else begin
            fs_q <= fs;
            if (start) begin
                // byte taken from the sync period (R5)
                if (m == SYNC_LONG) begin
                    sh  <= word << 1;
                    rem <= CW'(W - 1);
                end else begin
                    sh  <= word;
                    rem <= CW'(W);
                end
            end else if (!idle) begin
                sh  <= sh << 1;
                rem <= rem - 1'b1;
            end
        end
    end

    assign active = first | ~idle;
    assign bit_o  = first ? word[W-1] : (idle ? 1'b0 : sh[W-1]);

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_slot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         long_frame,
    input  logic         fs,
    input  logic         smp,
    output logic [W-1:0] word,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    logic          fs_q;
    logic [W-1:0]  sh;
    logic [CW-1:0] rem;
    sync_mode_e    m;
    logic          idle;
    logic          start;
    logic [W-1:0]  sh_next;

    assign m       = mode_of(long_frame);
    assign idle    = (rem == '0);
    assign start   = slot_start(m, fs, fs_q, idle);
    assign sh_next = {sh[W-2:0], smp};

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q  <= 1'b0;
            sh    <= '0;
            rem   <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            fs_q  <= fs;
            valid <= 1'b0;
            if (start) begin
                if (m == SYNC_LONG) begin
                    // bit of the sync period is already in smp (R7)
                    sh  <= sh_next;
                    rem <= CW'(W - 1);
                end else begin
                    rem <= CW'(W);
                end
            end else if (!idle) begin
                sh  <= sh_next;
                rem <= rem - 1'b1;
                if (rem == CW'(1)) begin
                    word  <= sh_next;
                    valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_tx_merge.sv
module pcm_tx_merge #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] active,
    input  logic [NCH-1:0] bits,
    output logic           drive,
    output logic           bit_o,
    output logic           overlap
);
    localparam int NW = $clog2(NCH + 1);

    logic [NW-1:0] n_act;

    // lowest-numbered active channel wins (R9)
    always_comb begin
        bit_o = 1'b0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (active[c]) bit_o = bits[c];
        end
    end

    always_comb begin
        n_act = '0;
        for (int c = 0; c < NCH; c++) n_act = n_act + NW'(active[c]);
    end

    assign drive   = |active;
    assign overlap = (n_act > NW'(1));

endmodule

// File: rtl/pcm_slot_if.sv
module pcm_slot_if #(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             long_frame,
    input  logic [NCH-1:0]   tx_fsync,
    input  logic [NCH*W-1:0] tx_word,
    output logic             tx_bit,
    output logic             tx_drive,
    output logic             tx_overlap,
    input  logic [NCH-1:0]   rx_fsync,
    input  logic             rx_bit,
    output logic [NCH*W-1:0] rx_word,
    output logic [NCH-1:0]   rx_valid
);
    logic [NCH-1:0] lane_active;
    logic [NCH-1:0] lane_bit;
    logic           rx_smp;

    // receive line sampled mid-period on the falling edge (R6, R7)
    always_ff @(negedge clk) begin
        if (rst) rx_smp <= 1'b0;
        else     rx_smp <= rx_bit;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pcm_tx_lane #(.W(W)) u_tx (
            .clk       (clk),
            .rst       (rst),
            .long_frame(long_frame),
            .fs        (tx_fsync[c]),
            .word      (tx_word[c*W +: W]),
            .active    (lane_active[c]),
            .bit_o     (lane_bit[c])
        );

        pcm_rx_lane #(.W(W)) u_rx (
            .clk       (clk),
            .rst       (rst),
            .long_frame(long_frame),
            .fs        (rx_fsync[c]),
            .smp       (rx_smp),
            .word      (rx_word[c*W +: W]),
            .valid     (rx_valid[c])
        );
    end

    pcm_tx_merge #(.NCH(NCH)) u_merge (
        .active (lane_active),
        .bits   (lane_bit),
        .drive  (tx_drive),
        .bit_o  (tx_bit),
        .overlap(tx_overlap)
    );

endmodule

// File: rtl/pcm_slot_if_chk.sv
module pcm_slot_if_chk #(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_bit,
    input logic             tx_drive,
    input logic             tx_overlap,
    input logic [NCH*W-1:0] rx_word,
    input logic [NCH-1:0]   rx_valid
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (rx_valid == '0 && rx_word == '0));

    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_drive |-> !tx_bit);

    // R9
    overlap_drive_chk: assert property (@(posedge clk) disable iff (rst)
        tx_overlap |-> tx_drive);

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_word) |-> (rx_valid != '0));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R6
        valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            rx_valid[c] |=> !rx_valid[c]);
    end

endmodule

bind pcm_slot_if pcm_slot_if_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_bit    (tx_bit),
    .tx_drive  (tx_drive),
    .tx_overlap(tx_overlap),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid)
);

// File: tb/pcm_slot_if_test.sv
`timescale 1ns/1ps
module pcm_slot_if_test;
    localparam int NCH = 4;
    localparam int W   = 8;
    localparam int P   = 24;

    logic             clk = 1'b0;
    logic             rst;
    logic             long_frame;
    logic [NCH-1:0]   tx_fsync;
    logic [NCH*W-1:0] tx_word;
    logic             tx_bit, tx_drive, tx_overlap;
    logic [NCH-1:0]   rx_fsync;
    logic             rx_bit;
    logic [NCH*W-1:0] rx_word;
    logic [NCH-1:0]   rx_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // scenario description
    int       t_start [NCH];
    int       r_start [NCH];
    logic [7:0] t_dat [NCH];
    logic [7:0] r_dat [NCH];
    logic [7:0] shadow [NCH];
    bit       run_mode;
    int       flip_p;
    int       re_p;
    bit       scramble;
    string    tx_tag;

    always #4 clk = ~clk;

    pcm_slot_if #(.NCH(NCH), .W(W)) uut (
        .clk(clk), .rst(rst), .long_frame(long_frame),
        .tx_fsync(tx_fsync), .tx_word(tx_word),
        .tx_bit(tx_bit), .tx_drive(tx_drive), .tx_overlap(tx_overlap),
        .rx_fsync(rx_fsync), .rx_bit(rx_bit),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int first_of(input int s, input bit m);
        return m ? s : s + 1;
    endfunction

    function automatic bit sync_hi(input int s, input int p, input bit m);
        if (s < 0) return 0;
        return m ? (p >= s && p < s + 8) : (p == s);
    endfunction

    task automatic clear_scen();
        for (int c = 0; c < NCH; c++) begin
            t_start[c] = -1; r_start[c] = -1; t_dat[c] = 8'h00; r_dat[c] = 8'h00;
        end
        flip_p = -1; re_p = -1; scramble = 0; tx_tag = "R2";
    endtask

    task automatic run_scen();
        for (int p = 0; p < P; p++) begin
            int  n_on;
            int  win;
            bit  rx_line;
            @(posedge clk); #1;
            long_frame = (flip_p >= 0 && p >= flip_p) ? ~run_mode : run_mode;
            rx_line = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                tx_fsync[c] = sync_hi(t_start[c], p, run_mode) | (c == 0 && p == re_p);
                rx_fsync[c] = sync_hi(r_start[c], p, run_mode);
                tx_word[c*W +: W] = (scramble && t_start[c] >= 0 && p > t_start[c]) ? ~t_dat[c] : t_dat[c];
                if (r_start[c] >= 0) begin
                    int f = first_of(r_start[c], run_mode);
                    if (p >= f && p < f + 8) rx_line = r_dat[c][7 - (p - f)];
                end
            end
            rx_bit = rx_line;
            #2;
            n_on = 0; win = -1;
            for (int c = NCH - 1; c >= 0; c--) begin
                if (t_start[c] >= 0) begin
                    int f = first_of(t_start[c], run_mode);
                    if (p >= f && p < f + 8) begin n_on++; win = c; end
                end
            end
            check(tx_drive == (n_on > 0), tx_tag, tx_drive, n_on > 0);
            check(tx_overlap == (n_on > 1), "R9", tx_overlap, n_on > 1);
            if (win >= 0) begin
                int f = first_of(t_start[win], run_mode);
                check(tx_bit == t_dat[win][7 - (p - f)], (n_on > 1) ? "R9" : tx_tag,
                      tx_bit, t_dat[win][7 - (p - f)]);
            end else begin
                check(tx_bit == 1'b0, "R4", tx_bit, 0);
            end
            for (int c = 0; c < NCH; c++) begin
                bit ev = 0;
                if (r_start[c] >= 0) ev = (p == first_of(r_start[c], run_mode) + 8);
                check(rx_valid[c] == ev, run_mode ? "R7" : "R6", rx_valid[c], ev);
                if (ev) begin
                    check(rx_word[c*W +: W] == r_dat[c], run_mode ? "R7" : "R6",
                          rx_word[c*W +: W], r_dat[c]);
                    shadow[c] = r_dat[c];
                end
            end
        end
        @(posedge clk); #1;
        tx_fsync = '0; rx_fsync = '0; rx_bit = 1'b0;
        #2;
        for (int c = 0; c < NCH; c++)
            check(rx_word[c*W +: W] == shadow[c], "R8", rx_word[c*W +: W], shadow[c]);
    endtask

    initial begin
        rst = 1'b1; long_frame = 1'b0; tx_fsync = '0; rx_fsync = '0;
        tx_word = '0; rx_bit = 1'b0;
        for (int c = 0; c < NCH; c++) shadow[c] = 8'h00;
        repeat (3) @(posedge clk);
        #3;
        check(rx_valid == '0, "R1", rx_valid, 0);
        check(rx_word == '0, "R1", 0, 0);
        check(tx_drive == 1'b0, "R1", tx_drive, 0);
        @(posedge clk); #1; rst = 1'b0;
        #2;
        check(rx_valid == '0 && rx_word == '0 && !tx_drive, "R1", rx_valid, 0);

        // sweep: both styles, every channel, several patterns (R2 R3 R6 R7)
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < NCH; c++) begin
                for (int k = 0; k < 3; k++) begin
                    clear_scen();
                    run_mode = m[0];
                    tx_tag = m ? "R3" : "R2";
                    t_start[c] = 2; r_start[c] = 2;
                    t_dat[c] = 8'((c * 37 + k * 91 + m * 13 + 129) % 256);
                    r_dat[c] = 8'((c * 53 + k * 71 + m * 29 + 6) % 256);
                    run_scen();
                end
            end
        end

        // R5: word changes after slot start
        for (int m = 0; m < 2; m++) begin
            clear_scen(); run_mode = m[0]; scramble = 1; tx_tag = "R5";
            t_start[1] = 3; t_dat[1] = 8'hA5;
            run_scen();
        end

        // R9: overlapping slots, short and long
        for (int m = 0; m < 2; m++) begin
            clear_scen(); run_mode = m[0]; tx_tag = "R9";
            t_start[1] = 2; t_dat[1] = 8'hC3;
            t_start[3] = 5; t_dat[3] = 8'h5A;
            t_start[2] = 8; t_dat[2] = 8'h0F;
            run_scen();
        end

        // R11: extra sync pulse during a short slot
        clear_scen(); run_mode = 1'b0; tx_tag = "R11";
        t_start[0] = 2; t_dat[0] = 8'h96; re_p = 5;
        run_scen();

        // R10: style change in the middle of a slot, both directions
        for (int m = 0; m < 2; m++) begin
            clear_scen(); run_mode = m[0]; tx_tag = "R10";
            t_start[2] = 2; t_dat[2] = 8'h3C;
            r_start[2] = 2; r_dat[2] = 8'hE1;
            flip_p = 5;
            run_scen();
        end

        // R8: receive on two channels back to back, others untouched
        clear_scen(); run_mode = 1'b0;
        r_start[0] = 1; r_dat[0] = 8'h81;
        r_start[3] = 11; r_dat[3] = 8'h7E;
        run_scen();

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule